// File: doc/BRIEF.md
# Multicycle Stored-Program Processor Core

This block is a small multicycle processor. Instructions and data share one memory, which sits outside the core behind a request channel and a response channel. A control state machine moves each 16-bit instruction through six phases in a fixed order: fetch, decode, evaluate address, fetch operands, execute and store. An instruction only enters the phases it needs. The memory phases last as long as the memory takes to answer.

The datapath has these parts:
- a program counter;
- an instruction register;
- eight 16-bit general registers;
- an ALU;
- a staging register for the memory address and one for the memory data.

The core executes five instructions: register add, register bitwise AND, bitwise NOT, load from base register plus signed offset, and jump to the address held in a register. A run-enable input freezes the whole core while it is low. The register-write port is visible at the top level, so a system can trace which instructions retired.

The memory request channel follows the valid/ready rules below:
- The core drives `mem_req_valid` and the memory drives `mem_req_ready`.
- A transfer takes place on a rising edge where both are high.
- `mem_addr` stays stable while a request waits.
- The core never has more than one request outstanding.

The response channel follows the same rules, with `mem_rsp_valid` from the memory and `mem_rsp_ready` from the core. The memory may hold off either channel for any number of cycles. Both handshake outputs are forced low while the run-enable is low, so no transfer happens while the core is frozen.

Top module: `vn_core`

## Requirements
- R1: While `rst_n` is low the program counter (`pc_o`) is 0 and all eight registers are cleared. After reset is released, the first memory request is a fetch from address 0.
- R2: A fetch reads the word at the program counter into the instruction register and adds 1 to the program counter. Straight-line code therefore requests consecutive addresses.
- R3: Opcode 0001 (add) writes SR1 + SR2 modulo 2^16 into DR. DR is bits [11:9], SR1 is bits [8:6] and SR2 is bits [2:0].
- R4: Opcode 0101 writes the bitwise AND of SR1 and SR2 into DR.
- R5: Opcode 1001 writes the bitwise inverse of SR1 into DR. Bits [5:0] hold all ones.
- R6: Opcode 0110 (load) reads memory at base + sign-extended bits [5:0] and writes the word into DR. The base register is in bits [8:6] and the address is formed modulo 2^16.
- R7: Opcode 1100 (jump) makes the next fetch read the address held in the register named by bits [8:6]. It writes no register.
- R8: Any other opcode writes no register. The next fetch then reads the following address.
- R9: With a memory that accepts every request at once and answers one cycle later, the instruction costs are: load 7 cycles, add/AND/NOT 6 cycles, jump 5 cycles, unknown opcode 3 cycles.
- R10: While `run_en` is low, the program counter and registers hold their values. No memory handshake and no register write take place. Execution resumes when `run_en` returns high.
- R11: Registers are written only in the store phase, never during fetch or decode.
- R12: The core issues no new memory request while a response is still outstanding. A request's address stays stable until the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | High lets the core advance; low freezes all state |
| mem_req_valid | output | 1 | Read request to memory is valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 16 | Request address, taken from the address staging register |
| mem_rsp_valid | input | 1 | Memory response data is valid |
| mem_rsp_ready | output | 1 | Core accepts the response |
| mem_rsp_data | input | 16 | Response word |
| pc_o | output | 16 | Current program counter |
| rf_we_o | output | 1 | Register write occurs this cycle |
| rf_waddr_o | output | 3 | Register written |
| rf_wdata_o | output | 16 | Value written |

## Verification
Each kind of internal error shows up at the ports within one instruction:
- A wrong program counter or address adder shows up at the next memory request as an unexpected address.
- A wrong ALU or operand latch shows up at that instruction's store as a wrong register index or value.
- A phase that should have been skipped, or a missing phase, shows up as a changed cycle gap between consecutive register writes when memory runs at full speed.

A stuck or leaking freeze shows up as a moving program counter or a handshake while run-enable is low.

// File: rtl/vn_pkg.sv
package vn_pkg;
  localparam logic [3:0] OPC_ADD = 4'b0001;
  localparam logic [3:0] OPC_AND = 4'b0101;
  localparam logic [3:0] OPC_NOT = 4'b1001;
  localparam logic [3:0] OPC_LDR = 4'b0110;
  localparam logic [3:0] OPC_JMP = 4'b1100;

  typedef enum logic [3:0] {
    PH_F_REQ, PH_F_RSP, PH_DEC, PH_EA, PH_OP_REQ,
    PH_OP_RSP, PH_OP_REG, PH_EX, PH_ST
  } phase_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_AND, ALU_NOT, ALU_PASS} alu_op_e;

  function automatic logic op_writes_reg(input logic [3:0] opc);
    return (opc == OPC_ADD) || (opc == OPC_AND) ||
           (opc == OPC_NOT) || (opc == OPC_LDR);
  endfunction
endpackage

// File: rtl/vn_alu.sv
module vn_alu
  import vn_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_op_e       op,
  output logic [DW-1:0] y
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_AND: y = a & b;
      ALU_NOT: y = ~a;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/vn_regfile.sv
module vn_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr1,
  input  logic [AW-1:0] raddr2,
  output logic [DW-1:0] rdata1,
  output logic [DW-1:0] rdata2
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                          regs[g] <= '0;
      else if (we && (waddr == AW'(g)))    regs[g] <= wdata;
    end
  end

  assign rdata1 = regs[raddr1];
  assign rdata2 = regs[raddr2];
endmodule

// File: rtl/vn_ctrl.sv
module vn_ctrl
  import vn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic [3:0] opc,
  input  logic       mem_req_ready,
  input  logic       mem_rsp_valid,
  output phase_e     phase,
  output logic       mem_req_valid,
  output logic       mem_rsp_ready,
  output logic       ld_ir,
  output logic       ld_ea,
  output logic       ld_mdr,
  output logic       ld_ops,
  output logic       ld_temp,
  output logic       ld_jmp,
  output logic       rf_we,
  output logic       go_fetch,
  output logic       sel_mdr,
  output alu_op_e    alu_op
);
  phase_e nxt;

  always_comb begin
    nxt           = phase;
    mem_req_valid = 1'b0;
    mem_rsp_ready = 1'b0;
    ld_ir = 1'b0; ld_ea = 1'b0; ld_mdr = 1'b0; ld_ops = 1'b0;
    ld_temp = 1'b0; ld_jmp = 1'b0; rf_we = 1'b0;
    case (phase)
      PH_F_REQ: begin
        mem_req_valid = run_en;
        if (mem_req_ready) nxt = PH_F_RSP;
      end
      PH_F_RSP: begin
        mem_rsp_ready = run_en;
        ld_ir         = run_en && mem_rsp_valid;
        if (mem_rsp_valid) nxt = PH_DEC;
      end
      PH_DEC: begin
        case (opc)
          OPC_ADD, OPC_AND, OPC_NOT, OPC_JMP: nxt = PH_OP_REG;
          OPC_LDR:                            nxt = PH_EA;
          default:                            nxt = PH_F_REQ;
        endcase
      end
      PH_EA: begin
        ld_ea = run_en;
        nxt   = PH_OP_REQ;
      end
      PH_OP_REQ: begin
        mem_req_valid = run_en;
        if (mem_req_ready) nxt = PH_OP_RSP;
      end
      PH_OP_RSP: begin
        mem_rsp_ready = run_en;
        ld_mdr        = run_en && mem_rsp_valid;
        if (mem_rsp_valid) nxt = PH_ST;
      end
      PH_OP_REG: begin
        ld_ops = run_en;
        nxt    = PH_EX;
      end
      PH_EX: begin
        if (opc == OPC_JMP) begin
          ld_jmp = run_en;
          nxt    = PH_F_REQ;
        end else begin
          ld_temp = run_en;
          nxt     = PH_ST;
        end
      end
      PH_ST: begin
        rf_we = run_en;
        nxt   = PH_F_REQ;
      end
      default: nxt = PH_F_REQ;
    endcase
  end

  assign go_fetch = run_en && (nxt == PH_F_REQ) && (phase != PH_F_REQ);
  assign sel_mdr  = (opc == OPC_LDR);

  always_comb begin
    case (opc)
      OPC_AND: alu_op = ALU_AND;
      OPC_NOT: alu_op = ALU_NOT;
      OPC_ADD: alu_op = ALU_ADD;
      default: alu_op = ALU_PASS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      phase <= PH_F_REQ;
    else if (run_en) phase <= nxt;
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R12
endmodule

// File: rtl/vn_core.sv
module vn_core
  import vn_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8,
  parameter int OFSW = 6,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [DW-1:0] mem_addr,
  input  logic          mem_rsp_valid,
  output logic          mem_rsp_ready,
  input  logic [DW-1:0] mem_rsp_data,
  output logic [DW-1:0] pc_o,
  output logic          rf_we_o,
  output logic [AW-1:0] rf_waddr_o,
  output logic [DW-1:0] rf_wdata_o
);
  logic [DW-1:0] pc_q, ir_q, mar_q, mdr_q, opa_q, opb_q, temp_q;
  logic [DW-1:0] rd1, rd2, alu_y, ea, pc_next;
  phase_e  phase;
  alu_op_e alu_op;
  logic ld_ir, ld_ea, ld_mdr, ld_ops, ld_temp, ld_jmp, rf_we, go_fetch, sel_mdr;

  vn_ctrl u_ctrl (
    .clk, .rst_n, .run_en,
    .opc(ir_q[15:12]),
    .mem_req_ready, .mem_rsp_valid,
    .phase, .mem_req_valid, .mem_rsp_ready,
    .ld_ir, .ld_ea, .ld_mdr, .ld_ops, .ld_temp, .ld_jmp,
    .rf_we, .go_fetch, .sel_mdr, .alu_op
  );

  vn_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk, .rst_n,
    .we(rf_we), .waddr(ir_q[11:9]), .wdata(rf_wdata_o),
    .raddr1(ir_q[8:6]), .raddr2(ir_q[2:0]),
    .rdata1(rd1), .rdata2(rd2)
  );

  vn_alu #(.DW(DW)) u_alu (.a(opa_q), .b(opb_q), .op(alu_op), .y(alu_y));

  assign ea      = rd1 + {{(DW-OFSW){ir_q[OFSW-1]}}, ir_q[OFSW-1:0]};
  assign pc_next = ld_jmp ? opa_q : pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= '0; ir_q <= '0; mar_q <= '0; mdr_q <= '0;
      opa_q <= '0; opb_q <= '0; temp_q <= '0;
    end else begin
      if (ld_ir) begin
        ir_q <= mem_rsp_data;
        pc_q <= pc_q + 1'b1;
      end
      if (ld_jmp)   pc_q  <= opa_q;
      if (go_fetch) mar_q <= pc_next;
      if (ld_ea)    mar_q <= ea;
      if (ld_mdr)   mdr_q <= mem_rsp_data;
      if (ld_ops) begin
        opa_q <= rd1;
        opb_q <= rd2;
      end
      if (ld_temp)  temp_q <= alu_y;
    end
  end

  assign mem_addr   = mar_q;
  assign pc_o       = pc_q;
  assign rf_we_o    = rf_we;
  assign rf_waddr_o = ir_q[11:9];
  assign rf_wdata_o = sel_mdr ? mdr_q : temp_q;

  AST_PC_HELD_IN_RESET: assert property (@(posedge clk)
    !rst_n |=> (pc_q == '0)); // R1
  AST_FETCH_STEPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ir |=> (pc_q == $past(pc_q) + 1'b1)); // R2
  AST_WRITE_KNOWN_OP: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> op_writes_reg(ir_q[15:12])); // R8
  AST_FROZEN_PC: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(pc_q)); // R10
  AST_FROZEN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(phase)); // R10
  AST_WRITE_AFTER_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> ($past(phase) == PH_EX || $past(phase) == PH_OP_RSP ||
               $past(phase) == PH_ST)); // R11
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> $stable(mem_addr)); // R12
endmodule

// File: tb/sim_vn_core.sv
`timescale 1ns/1ps
module sim_vn_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b1;
  logic mem_req_valid, mem_req_ready, mem_rsp_valid, mem_rsp_ready;
  logic [15:0] mem_addr, mem_rsp_data, pc_o, rf_wdata_o;
  logic rf_we_o;
  logic [2:0] rf_waddr_o;

  always #2 clk = ~clk;

  vn_core u0 (
    .clk, .rst_n, .run_en,
    .mem_req_valid, .mem_req_ready, .mem_addr,
    .mem_rsp_valid, .mem_rsp_ready, .mem_rsp_data,
    .pc_o, .rf_we_o, .rf_waddr_o, .rf_wdata_o
  );

  // program word, expected destination, expected value
  localparam logic [34:0] PROG [8] = '{
    {16'h6614, 3'd3, 16'h1234},  // R6 load R3 <- [R0+20]
    {16'h6C15, 3'd6, 16'h0F0F},  // R6 load R6 <- [R0+21]
    {16'h12C6, 3'd1, 16'h2143},  // R3 add
    {16'h58C6, 3'd4, 16'h0204},  // R4 and
    {16'h9AFF, 3'd5, 16'hEDCB},  // R5 not
    {16'h1F45, 3'd7, 16'hDB96},  // R3 add wraps modulo 2^16
    {16'h6416, 3'd2, 16'h0005},  // R6 load R2 <- [R0+22]
    {16'h68BF, 3'd4, 16'h9AFF}   // R6 negative offset reads instruction word
  };
  localparam logic [7:0] REQS [15] = '{0,20,1,21,2,3,4,5,6,22,7,4,8,9,5};
  localparam int GAPS [8] = '{7,6,6,6,6,7,7,14};

  logic [15:0] mem [64];
  logic pend = 1'b0, stall_en = 1'b1;
  logic [1:0] cnt = '0;
  logic [15:0] paddr = '0;
  logic [7:0] lfsr = 8'hA5;

  assign mem_req_ready = !pend && (!stall_en || lfsr[0]);
  assign mem_rsp_valid = pend && (cnt == 2'd0);
  assign mem_rsp_data  = mem[paddr[5:0]];

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (!rst_n) pend <= 1'b0;
    else if (run_en) begin
      if (mem_req_valid && mem_req_ready) begin
        pend <= 1'b1; paddr <= mem_addr; cnt <= stall_en ? lfsr[2:1] : 2'd0;
      end else if (pend && cnt != 2'd0) cnt <= cnt - 2'd1;
      else if (mem_rsp_valid && mem_rsp_ready) pend <= 1'b0;
    end
  end

  int checks = 0, errors = 0, cyc = 0, wbn = 0, rqn = 0, overlap = 0;
  logic [2:0]  wb_i [512];
  logic [15:0] wb_d [512];
  int          wb_t [512];
  logic [15:0] rq_a [512];
  int          rq_w [512];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && run_en) begin
      if (rf_we_o && wbn < 512) begin
        wb_i[wbn] = rf_waddr_o; wb_d[wbn] = rf_wdata_o; wb_t[wbn] = cyc; wbn = wbn + 1;
      end
      if (mem_req_valid && pend) overlap = overlap + 1;
      if (mem_req_valid && mem_req_ready && rqn < 512) begin
        rq_a[rqn] = mem_addr; rq_w[rqn] = wbn; rqn = rqn + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_count(input int target, input bit on_wb);
    for (int t = 0; t < 20000; t++) begin
      if ((on_wb ? wbn : rqn) >= target) return;
      @(negedge clk);
    end
    chk(on_wb ? "R2 wait writes" : "R2 wait requests", 0, 1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
    for (int i = 0; i < 8; i++) mem[i] = PROG[i][34:19];
    mem[8] = 16'hD000; mem[9] = 16'hC080;
    mem[20] = 16'h1234; mem[21] = 16'h0F0F; mem[22] = 16'h0005;
  end

  initial begin : watchdog
    #(200000 * 4);
    chk("watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int base, r0, p0, w0, q0;
    repeat (4) @(negedge clk);
    chk("R1 pc in reset", pc_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first fetch valid", mem_req_valid, 1);
    chk("R1 first fetch addr", mem_addr, 0);

    // stalled memory: table walk
    wait_count(9, 1'b1);
    wait_count(15, 1'b0);
    for (int k = 0; k < 8; k++) begin
      chk($sformatf("R3-6 stalled idx %0d", k), wb_i[k], PROG[k][18:16]);
      chk($sformatf("R3-6 stalled val %0d", k), wb_d[k], PROG[k][15:0]);
    end
    for (int k = 0; k < 15; k++)
      chk($sformatf("R2 R6 R7 request %0d", k), rq_a[k], REQS[k]);
    chk("R8 no write by unknown or jump", rq_w[14], 8);
    chk("R7 write after jump idx", wb_i[8], 3'd7);
    chk("R7 write after jump val", wb_d[8], 16'hDB96);
    chk("R12 no request while pending", overlap, 0);
    chk("R11 writes counted", (wbn >= 9), 1);

    // R10 freeze
    run_en = 1'b0;
    p0 = pc_o; w0 = wbn; q0 = rqn;
    repeat (20) @(negedge clk);
    chk("R10 pc held", pc_o, p0);
    chk("R10 no request", mem_req_valid, 0);
    chk("R10 no write", {rf_we_o, 31'(wbn - w0)}, 0);
    chk("R10 no transfer", rqn - q0, 0);
    run_en = 1'b1;
    wait_count(w0 + 1, 1'b1);
    chk("R10 resumes", (wbn > w0), 1);

    // R1 reset mid-run
    rst_n = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R1 pc during reset", pc_o, 0);
    end
    stall_en = 1'b0;
    base = wbn; r0 = rqn;
    rst_n = 1'b1;
    wait_count(base + 9, 1'b1);
    chk("R1 fetch from 0 after reset", rq_a[r0], 0);
    for (int k = 0; k < 8; k++) begin
      chk($sformatf("R1 R3-6 fast val %0d", k), wb_d[base + k], PROG[k][15:0]);
      chk($sformatf("R9 gap %0d", k), wb_t[base + k + 1] - wb_t[base + k], GAPS[k]);
    end
    chk("R7 fast jump result", wb_d[base + 8], 16'hDB96);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule